// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host end of a two-wire debug link. Each request names one debug-port or access-port register (2-bit address), says read or write, and carries a 32-bit write word. The engine then runs one complete transfer on the clock and data pins:

- the 8-bit request packet;
- a turnaround;
- the target's 3-bit acknowledge;
- the 32-bit data word with its parity bit, together with the turnarounds that surround it.

When the transfer ends it returns the acknowledge, the read word and a parity-error flag.

The link clock comes from a divider of the system clock, set by a static input. The turnaround length can be set at run time from one to four link clocks, and it is one clock after reset. A requester presents a request while `busy` is low and waits for the one-cycle `done` pulse. Retries, queueing and fault recovery belong to the layer above.

Top module: `swd_host`

## Requirements
- R1: After reset, `busy`, `done`, `swclk`, `swdio_oe`, `rsp_ack`, `rsp_rdata` and `rsp_par_err` are all zero, and the turnaround length is one link clock.
- R2: The request packet is sent LSB first as 8 bits. In wire order they are: start=1, port select (1 = access port), read flag (1 = read), `req_addr[0]`, `req_addr[1]`, parity, stop=0, park. Parity makes bits 1 to 5 hold an even number of ones. During the park bit the host releases the line (`swdio_oe`=0).
- R3: Each link bit lasts 2*(`clk_div`+1) system cycles. `swclk` is low for the first half and high for the second. The host changes its output only as `swclk` falls, and it samples `swdio_i` on the system edge where `swclk` rises.
- R4: Every turnaround lasts `cfg_trn`+1 link clocks, and the host does not drive the line during it. One turnaround follows the request packet.
- R5: The acknowledge is 3 bits sampled LSB first with the line released. 3'b001 is OK, 3'b010 is WAIT and 3'b100 is FAULT.
- R6: A read with OK samples 32 data bits LSB first, then a parity bit, then runs one turnaround. `rsp_rdata` then holds the word. `rsp_par_err` is 1 exactly when the 33 sampled bits hold an odd number of ones.
- R7: A write with OK runs one turnaround. The host then drives the 32 data bits LSB first, followed by their even-parity bit.
- R8: Any acknowledge other than 3'b001 is followed by one turnaround and then completion, with no data phase. `rsp_ack` reports the value, `rsp_par_err` is 0 and `rsp_rdata` keeps its previous value.
- R9: A request is taken on a clock edge where `req_valid` is 1 and `busy` is 0. `busy` is 1 from the next cycle until completion. `done` pulses for one cycle with `busy` low. `req_valid` while busy has no effect.
- R10: `cfg_we` loads `cfg_trn` only while `busy` is 0. A write while busy is ignored.
- R11: While idle, `swclk` is low and the host does not drive the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Half link period minus one, in system cycles (static) |
| cfg_we | input | 1 | Load turnaround setting |
| cfg_trn | input | 2 | Turnaround length minus one |
| req_valid | input | 1 | Request present |
| req_ap | input | 1 | 1 = access port, 0 = debug port |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_addr | input | 2 | Register address bits 3:2 |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_ack | output | 3 | Acknowledge of last transfer |
| rsp_rdata | output | DATA_W | Data of last successful read |
| rsp_par_err | output | 1 | Read parity mismatch |
| swclk | output | 1 | Link clock |
| swdio_o | output | 1 | Host data out |
| swdio_oe | output | 1 | Host drive enable |
| swdio_i | input | 1 | Line value in |

## Verification
The assertions assume three things about the inputs:
- `clk_div` does not change while a transfer runs;
- `swdio_i` behaves as a target does, driving only its own acknowledge and read windows;
- request fields matter only on the accepting edge.

The stimulus changes the divider and the turnaround length only between transfers, except for deliberate mid-transfer writes that must be ignored. Its target model holds the line high (pulled up) outside its own bit windows. It reports each acknowledge value, including an all-ones value as from an absent target, and drives read parity correct or deliberately wrong.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_REQ,
    PH_TRN,
    PH_ACK,
    PH_RDAT,
    PH_WDAT
  } phase_t;

  typedef enum logic [1:0] {
    TK_ACK,
    TK_WDAT,
    TK_END
  } trn_kind_t;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  localparam int REQ_BITS = 8;
  localparam int ACK_BITS = 3;

  // Request byte in wire order, bit 0 leaves first.
  function automatic logic [REQ_BITS-1:0] build_req(input logic ap, input logic rd,
                                                    input logic [1:0] a);
    logic p;
    p = ap ^ rd ^ a[0] ^ a[1];
    return {1'b1, 1'b0, p, a[1], a[0], rd, ap, 1'b1};
  endfunction

endpackage

// File: rtl/swd_clkgen.sv
module swd_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             swclk,
  output logic             rise,
  output logic             fall
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             ck_q, ck_d;
  logic             wrap;

  assign wrap = run && (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    ck_d  = ck_q;
    if (!run) begin
      cnt_d = '0;
      ck_d  = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      ck_d  = ~ck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ck_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ck_q  <= ck_d;
    end
  end

  assign swclk = ck_q;
  assign rise  = wrap && !ck_q;
  assign fall  = wrap && ck_q;

endmodule

// File: rtl/swd_shreg.sv
module swd_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         sh_in,
  input  logic         din,
  input  logic         sh_out,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (ld)          q_d = ld_val;
    else if (sh_in)  q_d = {din, q[W-1:1]};
    else if (sh_out) q_d = {1'b0, q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= q_d;
  end

endmodule

// File: rtl/swd_seq.sv
module swd_seq
  import swd_host_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             start,
  input  logic             is_rd,
  input  logic [1:0]       trn_last,
  input  logic             fall,
  input  logic [2:0]       ack_val,
  output phase_t           phase,
  output logic [CNT_W-1:0] bitcnt,
  output logic             finish,
  output logic             rd_ok
);

  localparam logic [CNT_W-1:0] REQ_LAST = CNT_W'(REQ_BITS - 1);
  localparam logic [CNT_W-1:0] ACK_LAST = CNT_W'(ACK_BITS - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W);

  phase_t           ph_q, ph_d;
  trn_kind_t        kind_q, kind_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rd_q, rd_d;
  logic             ok_q, ok_d;

  always_comb begin
    ph_d   = ph_q;
    kind_d = kind_q;
    cnt_d  = cnt_q;
    rd_d   = rd_q;
    ok_d   = ok_q;
    finish = 1'b0;
    if (ph_q == PH_IDLE) begin
      if (start) begin
        ph_d  = PH_REQ;
        cnt_d = '0;
        rd_d  = is_rd;
        ok_d  = 1'b0;
      end
    end else if (fall) begin
      cnt_d = cnt_q + 1'b1;
      unique case (ph_q)
        PH_REQ: if (cnt_q == REQ_LAST) begin
          ph_d   = PH_TRN;
          kind_d = TK_ACK;
          cnt_d  = '0;
        end
        PH_TRN: if (cnt_q == CNT_W'(trn_last)) begin
          cnt_d = '0;
          unique case (kind_q)
            TK_ACK:  ph_d = PH_ACK;
            TK_WDAT: ph_d = PH_WDAT;
            default: begin
              ph_d   = PH_IDLE;
              finish = 1'b1;
            end
          endcase
        end
        PH_ACK: if (cnt_q == ACK_LAST) begin
          cnt_d = '0;
          if (ack_val != ACK_OK) begin
            ph_d   = PH_TRN;
            kind_d = TK_END;
          end else if (rd_q) begin
            ph_d = PH_RDAT;
          end else begin
            ph_d   = PH_TRN;
            kind_d = TK_WDAT;
          end
        end
        PH_RDAT: if (cnt_q == DAT_LAST) begin
          ph_d   = PH_TRN;
          kind_d = TK_END;
          cnt_d  = '0;
          ok_d   = 1'b1;
        end
        PH_WDAT: if (cnt_q == DAT_LAST) begin
          ph_d   = PH_IDLE;
          cnt_d  = '0;
          finish = 1'b1;
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      kind_q <= TK_ACK;
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
      rd_q   <= rd_d;
      ok_q   <= ok_d;
    end
  end

  assign phase  = ph_q;
  assign bitcnt = cnt_q;
  assign rd_ok  = ok_q;

endmodule

// File: rtl/swd_host.sv
module swd_host
  import swd_host_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_trn,
  input  logic              req_valid,
  input  logic              req_ap,
  input  logic              req_rd,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [2:0]        rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_par_err,
  output logic              swclk,
  output logic              swdio_o,
  output logic              swdio_oe,
  input  logic              swdio_i
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int SH_W  = DATA_W + 1;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  phase_t              phase;
  logic [CNT_W-1:0]    bitcnt;
  logic                finish, rd_ok;
  logic                rise, fall;
  logic                accept;
  logic [1:0]          trn_q, trn_d;
  logic [REQ_BITS-1:0] req_q, req_d;
  logic [ACK_BITS-1:0] ack_v;
  logic [SH_W-1:0]     dat_v;
  logic                done_d;
  logic [2:0]          ack_rq, ack_rd;
  logic [DATA_W-1:0]   rdat_q, rdat_d;
  logic                perr_q, perr_d;

  assign busy   = (phase != PH_IDLE);
  assign accept = req_valid && !busy;

  swd_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk   (clk),
    .rst_ni(rst_ni),
    .run   (busy),
    .div   (clk_div),
    .swclk (swclk),
    .rise  (rise),
    .fall  (fall)
  );

  swd_seq #(.DATA_W(DATA_W)) u_seq (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .start   (accept),
    .is_rd   (req_rd),
    .trn_last(trn_q),
    .fall    (fall),
    .ack_val (ack_v),
    .phase   (phase),
    .bitcnt  (bitcnt),
    .finish  (finish),
    .rd_ok   (rd_ok)
  );

  swd_shreg #(.W(ACK_BITS)) u_ack_sr (
    .clk   (clk),
    .rst_ni(rst_ni),
    .ld    (1'b0),
    .ld_val('0),
    .sh_in (rise && (phase == PH_ACK)),
    .din   (swdio_i),
    .sh_out(1'b0),
    .q     (ack_v)
  );

  swd_shreg #(.W(SH_W)) u_dat_sr (
    .clk   (clk),
    .rst_ni(rst_ni),
    .ld    (accept),
    .ld_val({^req_wdata, req_wdata}),
    .sh_in (rise && (phase == PH_RDAT)),
    .din   (swdio_i),
    .sh_out(fall && (phase == PH_WDAT)),
    .q     (dat_v)
  );

  // configuration and request byte
  always_comb begin
    trn_d = trn_q;
    req_d = req_q;
    if (cfg_we && !busy) trn_d = cfg_trn;
    if (accept)          req_d = build_req(req_ap, req_rd, req_addr);
  end

  // response
  always_comb begin
    done_d = finish;
    ack_rd = ack_rq;
    rdat_d = rdat_q;
    perr_d = perr_q;
    if (finish) begin
      ack_rd = ack_v;
      perr_d = 1'b0;
      if (rd_ok) begin
        rdat_d = dat_v[DATA_W-1:0];
        perr_d = ^dat_v;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      trn_q  <= 2'd0;
      req_q  <= '0;
      done   <= 1'b0;
      ack_rq <= 3'b000;
      rdat_q <= '0;
      perr_q <= 1'b0;
    end else begin
      trn_q  <= trn_d;
      req_q  <= req_d;
      done   <= done_d;
      ack_rq <= ack_rd;
      rdat_q <= rdat_d;
      perr_q <= perr_d;
    end
  end

  assign rsp_ack     = ack_rq;
  assign rsp_rdata   = rdat_q;
  assign rsp_par_err = perr_q;

  // pin drive
  always_comb begin
    swdio_oe = 1'b0;
    swdio_o  = 1'b0;
    if (phase == PH_REQ) begin
      swdio_oe = (bitcnt != CNT_W'(REQ_BITS - 1));
      swdio_o  = req_q[bitcnt[2:0]];
    end else if (phase == PH_WDAT) begin
      swdio_oe = 1'b1;
      swdio_o  = dat_v[0];
    end
  end

endmodule

// File: rtl/swd_host_chk.sv
module swd_host_chk (
  input logic       clk,
  input logic       rst_ni,
  input logic       req_valid,
  input logic       busy,
  input logic       done,
  input logic       swclk,
  input logic       swdio_o,
  input logic       swdio_oe,
  input logic [1:0] trn_q,
  input logic [2:0] rsp_ack,
  input logic       rsp_par_err
);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> !busy);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);

  assert_start_by_req_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy) |-> $past(req_valid));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> (!swclk && !swdio_oe));

  assert_oe_low_phase_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(swdio_oe) |-> !swclk);

  assert_dout_low_phase_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (swdio_oe && !$stable(swdio_o)) |-> !swclk);

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(trn_q));

  assert_nak_no_perr_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && rsp_ack != 3'b001) |-> !rsp_par_err);

endmodule

bind swd_host swd_host_chk u_chk (
  .clk        (clk),
  .rst_ni     (rst_ni),
  .req_valid  (req_valid),
  .busy       (busy),
  .done       (done),
  .swclk      (swclk),
  .swdio_o    (swdio_o),
  .swdio_oe   (swdio_oe),
  .trn_q      (trn_q),
  .rsp_ack    (rsp_ack),
  .rsp_par_err(rsp_par_err)
);

// File: tb/swd_host_test.sv
`timescale 1ns/1ps
module swd_host_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_div = 8'd0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_trn = 2'd0;
  logic        req_valid = 1'b0;
  logic        req_ap = 1'b0;
  logic        req_rd = 1'b0;
  logic [1:0]  req_addr = 2'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        swdio_i = 1'b1;
  logic        busy, done, rsp_par_err, swclk, swdio_o, swdio_oe;
  logic [2:0]  rsp_ack;
  logic [31:0] rsp_rdata;

  int          checks = 0;
  int          fails = 0;
  int          cur_trn = 1;
  logic [31:0] exp_rdata = 32'd0;

  always #2.5 clk = ~clk;

  swd_host uut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .cfg_we(cfg_we), .cfg_trn(cfg_trn),
    .req_valid(req_valid), .req_ap(req_ap), .req_rd(req_rd), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rsp_ack(rsp_ack),
    .rsp_rdata(rsp_rdata), .rsp_par_err(rsp_par_err), .swclk(swclk),
    .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic set_trn(input int len);
    @(negedge clk);
    cfg_we  = 1'b1;
    cfg_trn = 2'(len - 1);
    @(negedge clk);
    cfg_we  = 1'b0;
    cur_trn = len;
  endtask

  // Behavioural wire model: lists every link bit, then walks cycle by cycle.
  task automatic run_txn(input bit ap, input bit rd, input bit [1:0] a,
                         input bit [31:0] wd, input bit [2:0] tack,
                         input bit [31:0] trd, input bit flip, input bit poke,
                         input string ttag);
    bit    eoe[$];
    bit    eo[$];
    bit    ti[$];
    string etag[$];
    bit [7:0] rq;
    bit    exp_perr;
    int    p, n, b;
    rq = {1'b1, 1'b0, ap ^ rd ^ a[0] ^ a[1], a[1], a[0], rd, ap, 1'b1};
    for (int i = 0; i < 7; i++) begin
      eoe.push_back(1'b1); eo.push_back(rq[i]); ti.push_back(1'b1); etag.push_back("R2");
    end
    eoe.push_back(1'b0); eo.push_back(1'b0); ti.push_back(1'b1); etag.push_back("R2");
    for (int i = 0; i < cur_trn; i++) begin
      eoe.push_back(1'b0); eo.push_back(1'b0); ti.push_back(1'b1); etag.push_back(ttag);
    end
    for (int i = 0; i < 3; i++) begin
      eoe.push_back(1'b0); eo.push_back(1'b0); ti.push_back(tack[i]); etag.push_back("R5");
    end
    exp_perr = 1'b0;
    if (tack != 3'b001) begin
      for (int i = 0; i < cur_trn; i++) begin
        eoe.push_back(1'b0); eo.push_back(1'b0); ti.push_back(1'b1); etag.push_back("R8");
      end
    end else if (rd) begin
      for (int i = 0; i < 32; i++) begin
        eoe.push_back(1'b0); eo.push_back(1'b0); ti.push_back(trd[i]); etag.push_back("R6");
      end
      eoe.push_back(1'b0); eo.push_back(1'b0); ti.push_back((^trd) ^ flip); etag.push_back("R6");
      for (int i = 0; i < cur_trn; i++) begin
        eoe.push_back(1'b0); eo.push_back(1'b0); ti.push_back(1'b1); etag.push_back("R6");
      end
      exp_rdata = trd;
      exp_perr  = flip;
    end else begin
      for (int i = 0; i < cur_trn; i++) begin
        eoe.push_back(1'b0); eo.push_back(1'b0); ti.push_back(1'b1); etag.push_back("R7");
      end
      for (int i = 0; i < 32; i++) begin
        eoe.push_back(1'b1); eo.push_back(wd[i]); ti.push_back(1'b1); etag.push_back("R7");
      end
      eoe.push_back(1'b1); eo.push_back(^wd); ti.push_back(1'b1); etag.push_back("R7");
    end
    n = eoe.size();
    p = 2 * (int'(clk_div) + 1);

    @(negedge clk);
    req_valid = 1'b1; req_ap = ap; req_rd = rd; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k <= n * p; k++) begin
      if (k < n * p) begin
        b = k / p;
        swdio_i = ti[b];
        chk(busy == 1'b1, "R9", "busy during transfer", 32'(busy), 32'd1);
        chk(done == 1'b0, "R9", "done early", 32'(done), 32'd0);
        chk(swclk == ((k % p) >= (p / 2)), "R3", "swclk phase", 32'(swclk),
            32'((k % p) >= (p / 2)));
        chk(swdio_oe == eoe[b], etag[b], "drive enable", 32'(swdio_oe), 32'(eoe[b]));
        if (eoe[b])
          chk(swdio_o == eo[b], etag[b], "driven bit", 32'(swdio_o), 32'(eo[b]));
        if (poke && k == 5) begin
          req_valid = 1'b1; req_ap = ~ap; req_rd = ~rd; req_addr = ~a;
          cfg_we = 1'b1; cfg_trn = 2'd0;
        end
        if (poke && k == 6) begin
          req_valid = 1'b0; cfg_we = 1'b0;
        end
        @(negedge clk);
      end else begin
        swdio_i = 1'b1;
        chk(done == 1'b1, "R9", "done pulse", 32'(done), 32'd1);
        chk(busy == 1'b0, "R9", "busy at done", 32'(busy), 32'd0);
        chk(swclk == 1'b0 && swdio_oe == 1'b0, "R11", "idle pins",
            {30'd0, swclk, swdio_oe}, 32'd0);
        chk(rsp_ack == tack, "R5", "ack result", 32'(rsp_ack), 32'(tack));
        chk(rsp_rdata == exp_rdata, (tack == 3'b001) ? "R6" : "R8", "read data",
            rsp_rdata, exp_rdata);
        chk(rsp_par_err == exp_perr, (tack == 3'b001) ? "R6" : "R8", "parity flag",
            32'(rsp_par_err), 32'(exp_perr));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(busy == 0 && done == 0, "R1", "busy/done", {30'd0, busy, done}, 32'd0);
    chk(swclk == 0 && swdio_oe == 0, "R1", "pins", {30'd0, swclk, swdio_oe}, 32'd0);
    chk(rsp_ack == 0 && rsp_par_err == 0, "R1", "ack/perr", {28'd0, rsp_ack, rsp_par_err}, 32'd0);
    chk(rsp_rdata == 0, "R1", "rdata", rsp_rdata, 32'd0);

    // default turnaround of one (R1, R4), plain debug-port read
    run_txn(1'b0, 1'b1, 2'd0, 32'd0, 3'b001, 32'h2BA0_1477, 1'b0, 1'b0, "R1");
    clk_div = 8'd1;
    run_txn(1'b1, 1'b0, 2'd1, 32'hA5C3_0F81, 3'b001, 32'd0, 1'b0, 1'b0, "R4");
    run_txn(1'b1, 1'b1, 2'd3, 32'd0, 3'b001, 32'h8000_0001, 1'b1, 1'b0, "R4");
    // R8: non-OK acknowledges
    run_txn(1'b1, 1'b1, 2'd2, 32'd0, 3'b010, 32'hFFFF_FFFF, 1'b0, 1'b0, "R4");
    run_txn(1'b0, 1'b0, 2'd1, 32'h1234_5678, 3'b100, 32'd0, 1'b0, 1'b0, "R4");
    run_txn(1'b0, 1'b1, 2'd3, 32'd0, 3'b111, 32'd0, 1'b0, 1'b0, "R4");
    // R10: turnaround of four, poke while busy must be ignored (R9 too)
    clk_div = 8'd2;
    set_trn(4);
    run_txn(1'b1, 1'b1, 2'd3, 32'd0, 3'b001, 32'h7E00_00FF, 1'b0, 1'b1, "R4");
    run_txn(1'b0, 1'b0, 2'd2, 32'hFFFF_0000, 3'b001, 32'd0, 1'b0, 1'b0, "R10");
    clk_div = 8'd0;
    set_trn(2);
    run_txn(1'b0, 1'b0, 2'd0, 32'h0000_0001, 3'b001, 32'd0, 1'b0, 1'b1, "R10");
    run_txn(1'b1, 1'b1, 2'd1, 32'd0, 3'b001, 32'hDEAD_BEEF, 1'b1, 1'b0, "R4");
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", 32'(done), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule